// File: doc/BRIEF.md
# Switchable Video Overlay Mixer

This block sits inside a 640x480 display driver and decides what colour each screen position shows. Two 320x240 frame stores feed it: a camera image used as the background and a processor-drawn graphics layer used as the foreground. From the current screen coordinates it forms one read address, shared by both stores. Each stored pixel therefore covers a 2x2 block of screen pixels.

When the overlay switch is high, the mixer outputs the average of the camera and graphics pixels, computed separately for each colour channel. When the switch is low, the camera pixel passes through unchanged. Pixels are 8-bit RGB332. The red channel is in bits [7:5], the green channel in bits [4:2] and the blue channel in bits [1:0].

The frame stores answer one cycle after the address is presented. The switch and the active-video flag are carried through the pipeline so that they stay aligned with the returning data. The mixed pixel and its valid flag appear two cycles after the coordinates. Outside the active area the output is forced to black.

Top module: `ovl_mixer`

## Requirements
- R1: In the same cycle as the coordinates arrive, both read addresses equal (y>>1)*320 + (x>>1), computed combinationally from x and y.
- R2: `pix_valid` equals `vid_active` as it was presented two clock cycles earlier.
- R3: With the overlay switch high, each channel of the output is floor((camera+graphics)/2). The channels are red [7:5], green [4:2] and blue [1:0], and no carry passes between channels.
- R4: With the overlay switch low, the output equals the camera pixel exactly, whatever the graphics pixel holds.
- R5: When the delayed active flag is low, `pix_out` is 0x00.
- R6: While reset is asserted (active low) and after it is released, `pix_out` and `pix_valid` are 0 until the pipeline fills.
- R7: The four screen positions (2i,2j), (2i+1,2j), (2i,2j+1) and (2i+1,2j+1) all produce the same read address.
- R8: The overlay switch is sampled together with the coordinates, so a change of the switch affects exactly the pixel whose coordinates were presented in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovl_sw | input | 1 | Overlay switch: 1 selects the average, 0 selects the camera pixel |
| vid_active | input | 1 | Coordinates are inside the visible area |
| pix_x | input | 10 | Screen column, 0..639 |
| pix_y | input | 9 | Screen row, 0..479 |
| cam_addr | output | 17 | Camera store read address |
| gfx_addr | output | 17 | Graphics store read address |
| cam_rdata | input | 8 | Camera pixel, valid one cycle after the address |
| gfx_rdata | input | 8 | Graphics pixel, valid one cycle after the address |
| pix_out | output | 8 | Mixed RGB332 pixel |
| pix_valid | output | 1 | `pix_out` belongs to the visible area |

## Verification
The bench builds the mixer with its default parameters: a 640x480 screen and two 320x240 stores with 17-bit addresses. At these values the last screen position (639,479) must map to address 76799, so random and directed coordinates together cover the top and bottom of the address range. It also covers the odd/even neighbours that collapse onto one stored pixel. The bench models the stores as one-cycle functions of the address. Because those functions fill every channel with varied values, saturated channel sums and flips of the switch from one pixel to the next both occur.

// File: rtl/ovl_mix_pkg.sv
package ovl_mix_pkg;

    localparam int PIX_W  = 8;
    localparam int N_CHAN = 3;

    typedef logic [PIX_W-1:0] pix_t;

    // channel 0 = blue [1:0], 1 = green [4:2], 2 = red [7:5]
    function automatic int chan_lo(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            default: return 5;
        endcase
    endfunction

    function automatic int chan_w(input int idx);
        return (idx == 0) ? 2 : 3;
    endfunction

    typedef struct packed {
        logic sel;
        logic act1;
        logic act2;
        pix_t pix;
    } mix_state_t;

endpackage

// File: rtl/ovl_addr_gen.sv
module ovl_addr_gen #(
    parameter int H_RES  = 640,
    parameter int V_RES  = 480,
    parameter int XW     = $clog2(H_RES),
    parameter int YW     = $clog2(V_RES),
    parameter int ADDR_W = $clog2((H_RES / 2) * (V_RES / 2))
) (
    input  logic [XW-1:0]     pix_x,
    input  logic [YW-1:0]     pix_y,
    output logic [ADDR_W-1:0] addr
);
    localparam int SRC_W = H_RES / 2;

    logic [ADDR_W-1:0] row_d;
    logic [ADDR_W-1:0] col_d;

    always_comb begin
        row_d = ADDR_W'(pix_y >> 1);
        col_d = ADDR_W'(pix_x >> 1);
        addr  = row_d * ADDR_W'(SRC_W) + col_d;
    end
endmodule

// File: rtl/ovl_chan_avg.sv
module ovl_chan_avg #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] m
);
    logic [W:0] sum_d;

    always_comb begin
        sum_d = {1'b0, a} + {1'b0, b};
        m     = sum_d[W:1];
    end
endmodule

// File: rtl/ovl_pix_blend.sv
module ovl_pix_blend
    import ovl_mix_pkg::*;
(
    input  pix_t cam,
    input  pix_t gfx,
    input  logic sel,
    output pix_t mix
);
    pix_t avg_d;

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        localparam int LO = chan_lo(i);
        localparam int W  = chan_w(i);
        ovl_chan_avg #(.W(W)) u_avg (
            .a (cam[LO +: W]),
            .b (gfx[LO +: W]),
            .m (avg_d[LO +: W])
        );
    end

    always_comb begin
        mix = sel ? avg_d : cam;
    end
endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer
    import ovl_mix_pkg::*;
#(
    parameter int H_RES  = 640,
    parameter int V_RES  = 480,
    parameter int XW     = $clog2(H_RES),
    parameter int YW     = $clog2(V_RES),
    parameter int ADDR_W = $clog2((H_RES / 2) * (V_RES / 2))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovl_sw,
    input  logic              vid_active,
    input  logic [XW-1:0]     pix_x,
    input  logic [YW-1:0]     pix_y,
    output logic [ADDR_W-1:0] cam_addr,
    output logic [ADDR_W-1:0] gfx_addr,
    input  logic [7:0]        cam_rdata,
    input  logic [7:0]        gfx_rdata,
    output logic [7:0]        pix_out,
    output logic              pix_valid
);
    logic [ADDR_W-1:0] addr_d;
    pix_t              mix_d;
    mix_state_t        st_d, st_q;

    ovl_addr_gen #(
        .H_RES (H_RES), .V_RES (V_RES), .XW (XW), .YW (YW), .ADDR_W (ADDR_W)
    ) u_addr (
        .pix_x (pix_x),
        .pix_y (pix_y),
        .addr  (addr_d)
    );

    ovl_pix_blend u_blend (
        .cam (cam_rdata),
        .gfx (gfx_rdata),
        .sel (st_q.sel),
        .mix (mix_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sel  = ovl_sw;
        st_d.act1 = vid_active;
        st_d.act2 = st_q.act1;
        st_d.pix  = st_q.act1 ? mix_d : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cam_addr  = addr_d;
    assign gfx_addr  = addr_d;
    assign pix_out   = st_q.pix;
    assign pix_valid = st_q.act2;
endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk #(
    parameter int ADDR_W   = 17,
    parameter int ADDR_MAX = 76799
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovl_sw,
    input logic              vid_active,
    input logic [ADDR_W-1:0] cam_addr,
    input logic [ADDR_W-1:0] gfx_addr,
    input logic [7:0]        cam_rdata,
    input logic [7:0]        gfx_rdata,
    input logic [7:0]        pix_out,
    input logic              pix_valid
);
    function automatic logic [7:0] half_sum(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] r, g;
        logic [2:0] bl;
        r  = {1'b0, a[7:5]} + {1'b0, b[7:5]};
        g  = {1'b0, a[4:2]} + {1'b0, b[4:2]};
        bl = {1'b0, a[1:0]} + {1'b0, b[1:0]};
        return {r[3:1], g[3:1], bl[2:1]};
    endfunction

    // R1
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cam_addr == gfx_addr) && (int'(cam_addr) <= ADDR_MAX));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(vid_active, 2));

    // R5
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_out == 8'h00));

    // R4
    cam_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !$past(ovl_sw, 2)) |-> (pix_out == $past(cam_rdata)));

    // R3
    avg_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(ovl_sw, 2)) |-> (pix_out == half_sum($past(cam_rdata), $past(gfx_rdata))));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!pix_valid && pix_out == 8'h00));
endmodule

bind ovl_mixer ovl_mixer_chk #(
    .ADDR_W   (ADDR_W),
    .ADDR_MAX ((H_RES / 2) * (V_RES / 2) - 1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovl_sw     (ovl_sw),
    .vid_active (vid_active),
    .cam_addr   (cam_addr),
    .gfx_addr   (gfx_addr),
    .cam_rdata  (cam_rdata),
    .gfx_rdata  (gfx_rdata),
    .pix_out    (pix_out),
    .pix_valid  (pix_valid)
);

// File: tb/sim_ovl_mixer.sv
`timescale 1ns/1ps
module sim_ovl_mixer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ovl_sw = 0;
    logic        vid_active = 0;
    logic [9:0]  pix_x = '0;
    logic [8:0]  pix_y = '0;
    logic [16:0] cam_addr, gfx_addr;
    logic [7:0]  cam_rdata = '0, gfx_rdata = '0;
    logic [7:0]  pix_out;
    logic        pix_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // expected-output pipeline (two stages)
    logic [7:0] e1_pix = 0, e2_pix = 0;
    logic       e1_act = 0, e2_act = 0, e1_ovl = 0, e2_ovl = 0;

    always #2 clk = ~clk;

    ovl_mixer u0 (
        .clk (clk), .rst_n (rst_n), .ovl_sw (ovl_sw), .vid_active (vid_active),
        .pix_x (pix_x), .pix_y (pix_y), .cam_addr (cam_addr), .gfx_addr (gfx_addr),
        .cam_rdata (cam_rdata), .gfx_rdata (gfx_rdata),
        .pix_out (pix_out), .pix_valid (pix_valid)
    );

    function automatic logic [7:0] cam_f(input logic [16:0] a);
        logic [31:0] h;
        h = {15'd0, a} * 32'd2654435761;
        return h[23:16] ^ a[7:0];
    endfunction

    function automatic logic [7:0] gfx_f(input logic [16:0] a);
        logic [31:0] h;
        h = ({15'd0, a} + 32'd12345) * 32'd40503;
        return h[15:8] ^ {a[16:13], a[3:0]};
    endfunction

    function automatic logic [16:0] exp_addr(input int x, input int y);
        return 17'((y / 2) * 320 + (x / 2));
    endfunction

    function automatic logic [7:0] exp_mix(input logic [7:0] c, input logic [7:0] g, input logic s);
        int r, gr, b;
        if (!s) return c;
        r  = (int'(c[7:5]) + int'(g[7:5])) / 2;
        gr = (int'(c[4:2]) + int'(g[4:2])) / 2;
        b  = (int'(c[1:0]) + int'(g[1:0])) / 2;
        return {3'(r), 3'(gr), 2'(b)};
    endfunction

    // one-cycle read ports
    always @(posedge clk) begin
        cam_rdata <= cam_f(cam_addr);
        gfx_rdata <= gfx_f(gfx_addr);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one pixel slot: check the result due now, then present new coordinates
    task automatic step(input int x, input int y, input logic act, input logic s);
        logic [16:0] a;
        @(negedge clk);
        check("R2", 32'(pix_valid), 32'(e2_act));
        if (!e2_act)     check("R5", 32'(pix_out), 32'(0));
        else if (e2_ovl) check("R3/R8", 32'(pix_out), 32'(e2_pix));
        else             check("R4/R8", 32'(pix_out), 32'(e2_pix));
        e2_pix = e1_pix; e2_act = e1_act; e2_ovl = e1_ovl;
        pix_x = 10'(x); pix_y = 9'(y); vid_active = act; ovl_sw = s;
        a = exp_addr(x, y);
        e1_act = act; e1_ovl = s;
        e1_pix = act ? exp_mix(cam_f(a), gfx_f(a), s) : 8'h00;
        #1;
        check("R1", 32'(cam_addr), 32'(a));
        check("R1", 32'(gfx_addr), 32'(a));
    endtask

    initial begin
        void'($urandom(32'd77));
        // R6: outputs cleared during reset
        repeat (3) @(negedge clk);
        check("R6", 32'(pix_valid), 32'(0));
        check("R6", 32'(pix_out), 32'(0));
        rst_n = 1;
        // R6: still cleared right after release
        @(negedge clk);
        check("R6", 32'(pix_valid), 32'(0));
        check("R6", 32'(pix_out), 32'(0));

        // R1 corners
        step(0, 0, 1, 0);
        step(639, 479, 1, 1);
        check("R1 last address", 32'(cam_addr), 32'd76799);
        step(638, 478, 1, 0);
        step(1, 0, 1, 1);
        step(0, 1, 0, 1);
        // R7: four positions of one 2x2 block share an address
        step(200, 100, 1, 1);
        step(201, 100, 1, 1);
        check("R7", 32'(cam_addr), 32'(exp_addr(200, 100)));
        step(200, 101, 1, 0);
        check("R7", 32'(cam_addr), 32'(exp_addr(200, 100)));
        step(201, 101, 1, 1);
        check("R7", 32'(cam_addr), 32'(exp_addr(200, 100)));
        // R8: switch toggles every pixel along a line
        for (int i = 0; i < 40; i++) step(300 + i, 240, 1, i[0]);
        // R5: blanking run
        for (int i = 0; i < 6; i++) step(i, 10, 0, 1);

        // random mix
        for (int i = 0; i < 3000; i++)
            step($urandom_range(639), $urandom_range(479),
                 ($urandom_range(7) != 0), 1'($urandom_range(1)));

        // drain the pipeline
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule